// File: doc/BRIEF.md
# Lookahead Issue Gate

This block decides, on every clock cycle, which of several hardware threads may send one instruction into a long shared pipeline. It does not use a register scoreboard. Each instruction carries a small count, written by the compiler, of how many of the same thread's following instructions do not depend on it. The gate turns that count into issue credit for the thread. When the credit is used up, the thread waits until the instruction that opened its window completes. Threads that are eligible are served in rotating order.

The pipeline sits next to this block. Each instruction takes 21 cycles, or 150 cycles for a memory access. It returns a completion event holding the thread number and the tag that the gate gave the instruction at issue. A thread whose instructions all carry a count of 0 therefore issues at most once per pipeline latency. Decode and memory are outside this block.

Top module: `issue_gate`

## Requirements
- R1: At most one instruction issues per cycle. When `issue_valid` is high, `issue_tid` names a thread with `thr_active` and `instr_avail` high that is not blocked. The grant is combinational in the same cycle as the request.
- R2: A thread with `thr_active` low or `instr_avail` low never issues, whatever its credit state.
- R3: A thread with no outstanding window opens one when it issues. Its lookahead field, bits `[t*3 +: 3]` of `instr_look` for thread t, gives L in 0..7. The thread may then issue L further instructions before it blocks.
- R4: A thread that issues with lookahead 0 from an open state is blocked from the next cycle. It stays blocked until the completion event for that instruction.
- R5: A completion event with `cmpl_tid` equal to the thread and `cmpl_tag` equal to the tag of the instruction that opened its window unblocks the thread from the next cycle.
- R6: A completion event with a different thread number or a different tag leaves every thread's state unchanged.
- R7: A matching completion that arrives while a window still has credit closes the window. The thread's next issue opens a fresh window with its own lookahead. This holds also when the thread issues in the same cycle as the completion.
- R8: The lookahead field of an instruction issued inside an open window is ignored.
- R9: Selection rotates. After thread t is granted, the search in the next cycle starts at thread t+1, wrapping from the last thread to thread 0.
- R10: `issue_tag` is a per-thread sequence number. It is 0 for each thread's first issue after reset and increases by 1, modulo 2^TAG_W, with each issue of that thread.
- R11: After reset every thread is open with no window, and the rotation starts at thread 0.
- R12: Whenever at least one thread is eligible, an instruction issues in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_active | input | NUM_THR | Thread is running |
| instr_avail | input | NUM_THR | Thread has an instruction ready |
| instr_look | input | NUM_THR*LOOK_W | Lookahead count of each thread's ready instruction |
| cmpl_valid | input | 1 | A completion event is present |
| cmpl_tid | input | clog2(NUM_THR) | Thread of the completing instruction |
| cmpl_tag | input | TAG_W | Tag of the completing instruction |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | clog2(NUM_THR) | Thread granted |
| issue_tag | output | TAG_W | Tag given to the issued instruction |

## Verification
Two functions can fall in the same cycle: a thread issuing inside its window, and the completion of the instruction that opened that window. Directed stimulus forces this collision on one thread. Random traffic with mixed 21- and 150-cycle completion delays produces many more such collisions. The cycle-level model in the bench expects the window to close, so the thread's next issue must open a new window sized by its current lookahead. Any other outcome shows up as a tag or grant mismatch in a later cycle.

// File: rtl/ig_pkg.sv
// Shared types of the lookahead issue gate.
package ig_pkg;
    // Credit state of one thread as seen by the arbiter.
    typedef enum logic [1:0] {
        CTX_OPEN    = 2'd0,   // no window outstanding
        CTX_WINDOW  = 2'd1,   // window outstanding, credit left
        CTX_BLOCKED = 2'd2    // window outstanding, credit spent
    } ctx_state_e;
endpackage

// File: rtl/ig_thread_ctx.sv
// Per-thread issue context. Keeps the sequence counter that tags the
// thread's instructions, plus the current lookahead window: a pending
// flag, the remaining credit and the tag of the instruction that opened
// the window.
// Assumes issue_now is only raised when state is not CTX_BLOCKED.
module ig_thread_ctx
    import ig_pkg::*;
#(
    parameter int LOOK_W = 3,
    parameter int TAG_W  = 5,
    parameter int TID_W  = 3,
    parameter int MY_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_now,
    input  logic [LOOK_W-1:0] look,
    input  logic              cmpl_valid,
    input  logic [TID_W-1:0]  cmpl_tid,
    input  logic [TAG_W-1:0]  cmpl_tag,
    output ctx_state_e        state,
    output logic [TAG_W-1:0]  next_tag
);
    localparam logic [TID_W-1:0] SELF = TID_W'(MY_ID);

    logic              pending;
    logic [LOOK_W-1:0] credit;
    logic [TAG_W-1:0]  anchor;
    logic [TAG_W-1:0]  seq;
    logic              hit;

    // Completion matches the window-opening instruction of this thread.
    assign hit = cmpl_valid && (cmpl_tid == SELF) && pending && (cmpl_tag == anchor);

    // Report the credit state to the arbiter.
    always_comb begin
        if (!pending)
            state = CTX_OPEN;
        else if (credit != '0)
            state = CTX_WINDOW;
        else
            state = CTX_BLOCKED;
    end

    assign next_tag = seq;

    // Advance the tag sequence on every issue.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq <= '0;
        else if (issue_now)
            seq <= seq + 1'b1;
    end

    // Open, consume or close the lookahead window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            credit  <= '0;
            anchor  <= '0;
        end else if (hit) begin
            pending <= 1'b0;
            credit  <= '0;
        end else if (issue_now) begin
            if (!pending) begin
                pending <= 1'b1;
                credit  <= look;
                anchor  <= seq;
            end else begin
                credit  <= credit - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ig_rr_pick.sv
// Rotating-priority picker. Grants the first requester at or after
// the pointer; the pointer then moves to one past the winner.
// Assumes N >= 2.
module ig_rr_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          pick_valid,
    output logic [IW-1:0] pick_idx
);
    logic [IW-1:0] ptr;
    int            s;

    // Scan from the pointer; the smallest offset wins.
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        s          = 0;
        for (int k = N - 1; k >= 0; k--) begin
            s = int'(ptr) + k;
            if (s >= N) s = s - N;
            if (req[s[IW-1:0]]) begin
                pick_valid = 1'b1;
                pick_idx   = s[IW-1:0];
            end
        end
    end

    // Move the pointer past the last winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (pick_valid)
            ptr <= (pick_idx == IW'(N - 1)) ? '0 : pick_idx + 1'b1;
    end
endmodule

// File: rtl/issue_gate.sv
// Lookahead-driven issue gate. Every cycle it grants at most one
// thread the right to issue. A thread is eligible when it is active,
// has an instruction ready and is not blocked on its window-opening
// instruction. The returned tag identifies the instruction in later
// completion events.
// Assumes completions are presented one per cycle with the tag handed
// out at issue.
module issue_gate
    import ig_pkg::*;
#(
    parameter  int NUM_THR = 8,
    parameter  int LOOK_W  = 3,
    parameter  int TAG_W   = 5,
    localparam int TID_W   = $clog2(NUM_THR)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_THR-1:0]        thr_active,
    input  logic [NUM_THR-1:0]        instr_avail,
    input  logic [NUM_THR*LOOK_W-1:0] instr_look,
    input  logic                      cmpl_valid,
    input  logic [TID_W-1:0]          cmpl_tid,
    input  logic [TAG_W-1:0]          cmpl_tag,
    output logic                      issue_valid,
    output logic [TID_W-1:0]          issue_tid,
    output logic [TAG_W-1:0]          issue_tag
);
    logic [NUM_THR-1:0] elig_vec;
    logic [NUM_THR-1:0] blocked_vec;
    logic [NUM_THR-1:0] grant_vec;
    logic [TAG_W-1:0]   tag_arr [NUM_THR];
    ctx_state_e         st_arr  [NUM_THR];

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        ig_thread_ctx #(
            .LOOK_W (LOOK_W),
            .TAG_W  (TAG_W),
            .TID_W  (TID_W),
            .MY_ID  (g)
        ) u_ctx (
            .clk        (clk),
            .rst_n      (rst_n),
            .issue_now  (grant_vec[g]),
            .look       (instr_look[g*LOOK_W +: LOOK_W]),
            .cmpl_valid (cmpl_valid),
            .cmpl_tid   (cmpl_tid),
            .cmpl_tag   (cmpl_tag),
            .state      (st_arr[g]),
            .next_tag   (tag_arr[g])
        );
        // Per-thread eligibility and one-hot grant decode.
        assign blocked_vec[g] = (st_arr[g] == CTX_BLOCKED);
        assign elig_vec[g]    = thr_active[g] & instr_avail[g] & ~blocked_vec[g];
        assign grant_vec[g]   = issue_valid && (issue_tid == TID_W'(g));
    end

    ig_rr_pick #(
        .N  (NUM_THR),
        .IW (TID_W)
    ) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (elig_vec),
        .pick_valid (issue_valid),
        .pick_idx   (issue_tid)
    );

    // Hand out the granted thread's sequence tag.
    assign issue_tag = issue_valid ? tag_arr[issue_tid] : '0;
endmodule

// File: rtl/issue_gate_chk.sv
// Property checker for issue_gate, attached by bind.
module issue_gate_chk #(
    parameter int NUM_THR = 8,
    parameter int TAG_W   = 5,
    parameter int TID_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_THR-1:0] thr_active,
    input logic [NUM_THR-1:0] instr_avail,
    input logic [NUM_THR-1:0] elig_vec,
    input logic [NUM_THR-1:0] blocked_vec,
    input logic               issue_valid,
    input logic [TID_W-1:0]   issue_tid,
    input logic [TAG_W-1:0]   issue_tag
);
    logic armed;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_grant_is_live: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (thr_active[issue_tid] && instr_avail[issue_tid] && !blocked_vec[issue_tid]));

    a_r2_idle_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr_active & instr_avail) == '0) |-> !issue_valid);

    a_r12_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_vec != '0) |-> issue_valid);

    a_r9_repeat_only_if_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && issue_valid && $past(issue_valid) && issue_tid == $past(issue_tid))
            |-> ($countones(elig_vec) == 1));

    a_r10_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && issue_valid && $past(issue_valid) && issue_tid == $past(issue_tid))
            |-> (issue_tag == TAG_W'($past(issue_tag) + 1'b1)));
endmodule

bind issue_gate issue_gate_chk #(
    .NUM_THR (NUM_THR),
    .TAG_W   (TAG_W),
    .TID_W   (TID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .thr_active  (thr_active),
    .instr_avail (instr_avail),
    .elig_vec    (elig_vec),
    .blocked_vec (blocked_vec),
    .issue_valid (issue_valid),
    .issue_tid   (issue_tid),
    .issue_tag   (issue_tag)
);

// File: tb/sim_issue_gate.sv
// Bench for issue_gate: behavioural per-cycle reference model, compared
// every cycle at the falling edge.
module sim_issue_gate;
    localparam int PERIOD = 10;
    localparam int NT     = 8;
    localparam int LW     = 3;
    localparam int TW     = 5;
    localparam int IW     = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NT-1:0]  thr_active;
    logic [NT-1:0]  instr_avail;
    logic [NT*LW-1:0] instr_look;
    logic           cmpl_valid;
    logic [IW-1:0]  cmpl_tid;
    logic [TW-1:0]  cmpl_tag;
    logic           issue_valid;
    logic [IW-1:0]  issue_tid;
    logic [TW-1:0]  issue_tag;

    issue_gate #(.NUM_THR(NT), .LOOK_W(LW), .TAG_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .instr_avail(instr_avail),
        .instr_look(instr_look), .cmpl_valid(cmpl_valid), .cmpl_tid(cmpl_tid),
        .cmpl_tag(cmpl_tag), .issue_valid(issue_valid), .issue_tid(issue_tid),
        .issue_tag(issue_tag)
    );

    always #(PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 0;

    // reference model state
    int m_pend [NT];
    int m_cred [NT];
    int m_anch [NT];
    int m_seq  [NT];
    int m_ptr;

    // stimulus held for the next step
    logic [NT-1:0]    s_act, s_av;
    logic [NT*LW-1:0] s_look;
    logic             s_cv;
    int               s_ct, s_cg;
    bit               auto_cmpl = 0;

    // outstanding instructions awaiting completion
    int q_due[$];
    int q_tid[$];
    int q_tag[$];

    function automatic void model_reset();
        for (int t = 0; t < NT; t++) begin
            m_pend[t] = 0; m_cred[t] = 0; m_anch[t] = 0; m_seq[t] = 0;
        end
        m_ptr = 0;
    endfunction

    function automatic void set_look(int t, int v);
        s_look[t*LW +: LW] = LW'(v);
    endfunction

    // One cycle: drive, compare at the falling edge, advance the model.
    task automatic step(input string req);
        bit ev; int et; int eg; int l;
        @(posedge clk);
        #1;
        if (auto_cmpl && !s_cv) begin
            for (int i = 0; i < q_due.size(); i++) begin
                if (q_due[i] <= cyc) begin
                    s_cv = 1; s_ct = q_tid[i]; s_cg = q_tag[i];
                    q_due.delete(i); q_tid.delete(i); q_tag.delete(i);
                    break;
                end
            end
            if (!s_cv && ($urandom % 16 == 0)) begin
                s_cv = 1; s_ct = int'($urandom % NT); s_cg = int'($urandom % 32);
            end
        end
        thr_active  = s_act;
        instr_avail = s_av;
        instr_look  = s_look;
        cmpl_valid  = s_cv;
        cmpl_tid    = IW'(s_ct);
        cmpl_tag    = TW'(s_cg);
        #(PERIOD/2 - 1);
        ev = 0; et = 0; eg = 0;
        for (int k = 0; k < NT; k++) begin
            int t;
            t = (m_ptr + k) % NT;
            if (!ev && s_act[t] && s_av[t] && (m_pend[t] == 0 || m_cred[t] != 0)) begin
                ev = 1; et = t; eg = m_seq[t];
            end
        end
        n_chk++;
        if (issue_valid !== ev || (ev && (int'(issue_tid) != et || int'(issue_tag) != eg))) begin
            n_err++;
            $display("FAIL %s cycle %0d: got v=%0b tid=%0d tag=%0d expected v=%0b tid=%0d tag=%0d",
                     req, cyc, issue_valid, issue_tid, issue_tag, ev, et, eg);
        end
        for (int t = 0; t < NT; t++) begin
            bit h, g;
            h = s_cv && s_ct == t && m_pend[t] != 0 && s_cg == m_anch[t];
            g = ev && et == t;
            l = int'(s_look[t*LW +: LW]);
            if (h) begin
                m_pend[t] = 0; m_cred[t] = 0;
            end else if (g) begin
                if (m_pend[t] == 0) begin
                    m_pend[t] = 1; m_cred[t] = l; m_anch[t] = m_seq[t];
                end else begin
                    m_cred[t] = m_cred[t] - 1;
                end
            end
            if (g) m_seq[t] = (m_seq[t] + 1) % 32;
        end
        if (ev) begin
            m_ptr = (et + 1) % NT;
            q_due.push_back(cyc + (($urandom % 4 == 0) ? 150 : 21));
            q_tid.push_back(et);
            q_tag.push_back(eg);
        end
        s_cv = 0;
        cyc++;
    endtask

    // Watchdog: an overrun counts as a failed check.
    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: got running expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(7));
        rst_n = 0; s_act = '0; s_av = '0; s_look = '0; s_cv = 0; s_ct = 0; s_cg = 0;
        thr_active = '0; instr_avail = '0; instr_look = '0;
        cmpl_valid = 0; cmpl_tid = '0; cmpl_tag = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R11 / R10: all threads open, rotation starts at thread 0, tags 0
        s_act = '1; s_av = '1;
        step("R11");
        step("R10");
        // R2: nothing requested or only inactive threads available
        s_act = 8'h00; s_av = 8'hFF; step("R2");
        s_act = 8'h0F; s_av = 8'hF0; step("R2");
        s_act = '0; s_av = '0;
        for (int t = 0; t < NT; t++) begin
            s_cv = 1; s_ct = t; s_cg = m_anch[t]; step("R5");
        end

        // R4 / R6 / R5 on thread 3 with lookahead 0
        s_act = 8'h08; s_av = 8'h08; s_look = '0;
        step("R4");
        repeat (4) step("R4");
        s_cv = 1; s_ct = 3; s_cg = (m_anch[3] + 1) % 32; step("R6");
        s_cv = 1; s_ct = 2; s_cg = m_anch[3];             step("R6");
        step("R6");
        s_cv = 1; s_ct = 3; s_cg = m_anch[3]; step("R5");
        step("R5");
        s_cv = 1; s_ct = 3; s_cg = m_anch[3]; step("R5");

        // R3 / R8 on thread 5: lookahead 2 then 7 inside the window
        s_act = 8'h20; s_av = 8'h20; set_look(5, 2);
        step("R3");
        set_look(5, 7);
        step("R8"); step("R8"); step("R3"); step("R3");
        s_cv = 1; s_ct = 5; s_cg = m_anch[5]; step("R5");
        // R7: new window (lookahead 7), issue and complete anchor together
        step("R7");
        s_cv = 1; s_ct = 5; s_cg = m_anch[5]; step("R7");
        set_look(5, 0);
        step("R7"); step("R7"); step("R7");
        s_cv = 1; s_ct = 5; s_cg = m_anch[5]; step("R7");

        // R9 / R12 / R1: all threads, big windows, then sparse requests
        s_act = '1; s_av = '1; s_look = {NT{3'd7}};
        auto_cmpl = 1;
        repeat (24) step("R9");
        s_av = 8'b1000_0101;
        repeat (12) step("R9");
        repeat (12) step("R12");

        // random traffic with mixed completion delays
        for (int i = 0; i < 5000; i++) begin
            s_act  = NT'(~($urandom & $urandom & $urandom));
            s_av   = NT'($urandom | $urandom);
            s_look = (NT*LW)'($urandom & $urandom);
            step((i % 2 == 0) ? "R1" : "R7");
        end
        s_act = '0; s_av = '0;
        repeat (160) step("R12");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule